// File: doc/BRIEF.md
# Timing-Speculative Stage Register

This block is one pipeline stage register bank that tolerates data arriving after the rising clock edge. Every bit chosen by a parameter mask is guarded. It has a main flop that samples on the rising edge and a shadow flop on the same clock that samples on the falling edge. The shadow therefore sees the input half a cycle later than the main flop does. When the two disagree, the bit raises its error flag. The flags of the stage are ORed into a single restore signal. On the next rising edge the shadow value is copied into the main flop. The stage output is then correct one cycle after the errant cycle, and nothing has to be executed again.

Restore stays high for exactly one cycle, the recovery cycle. During that cycle the shadow flops do not capture. Bits that are not guarded are plain registers, and during recovery they hold their value so that the whole stage stays consistent in time. The input word presented at the rising edge that starts recovery is not captured, so the upstream stage must present it again.

A per-bit indication of a possible metastable main flop can also be fed in. It is treated exactly like a value mismatch.

Top module: `tspec_stage_reg`

## Requirements
- R1: While rst_ni is low, q_o, err_bits_o and restore_o are all zero.
- R2: When d_i is stable across both edges of a cycle, q_o equals d_i after that cycle's rising edge, and err_bits_o and restore_o stay zero.
- R3: If a guarded bit of d_i changes after the rising edge and before the falling edge, that bit of err_bits_o is 1 from that falling edge onward.
- R4: restore_o is the OR of err_bits_o. It rises at the falling edge of the errant cycle and falls at the next falling edge, so it lasts exactly one cycle.
- R5: At the rising edge that follows an error, the guarded bits of q_o take the value captured at the falling edge. The d_i value presented at that edge is not captured.
- R6: While restore_o is high, the unguarded bits of q_o hold their value across the rising edge.
- R7: During the recovery cycle the shadow flops do not capture. At the falling edge that ends recovery, no error is flagged even if d_i differs from q_o.
- R8: A 1 on a guarded bit of meta_i at a falling edge sets that bit of err_bits_o and starts a recovery cycle, just as a mismatch does. The value of q_o is unchanged by that recovery.
- R9: Bits outside PROT_MASK never flag an error. A late change or a meta_i pulse on such a bit leaves err_bits_o and restore_o at zero, and q_o keeps the value sampled at the rising edge.
- R10: A new error in the cycle directly after a recovery cycle is detected and repaired in the same way.
- R11: err_bits_o marks exactly the guarded bits whose rising-edge and falling-edge samples differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. The main flops sample on the rising edge, the shadow flops on the falling edge. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_i | input | W | Stage input word |
| meta_i | input | W | Per-bit metastability indication, sampled on the falling edge. Only guarded bits use it. |
| q_o | output | W | Stage output word |
| err_bits_o | output | W | Per-bit error flags, updated on the falling edge |
| restore_o | output | 1 | Stage restore, high for one recovery cycle |

## Verification
The error flags and restore are due half a cycle after the rising edge of the errant cycle, at its falling edge. The corrected q_o is due one full cycle after the errant rising edge. Restore falls at the falling edge one cycle after it rose.

Each task therefore drives inputs in a fixed phase. Early values are set in the low phase. Late values are set 2 ns after the rising edge. Results are sampled 1 ns after the edge that produced them: error and restore after falling edges, q_o after rising edges. The task also sets a conflicting next word before the repair edge, so the checks show that this word is dropped and that the shadow stays closed during recovery.

// File: rtl/tspec_pkg.sv
package tspec_pkg;
  parameter int unsigned DEF_WIDTH = 16;
  parameter logic [63:0] DEF_MASK  = 64'h0000_0000_0000_3C3C;

  typedef enum logic {
    MODE_RUN     = 1'b0,
    MODE_RECOVER = 1'b1
  } stage_mode_e;
endpackage

// File: rtl/tspec_prot_bit.sv
module tspec_prot_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic meta_i,
  input  logic restore_i,
  output logic q_o,
  output logic err_o,
  output logic err_next_o
);
  logic main_q, shadow_q, err_q;

  // rising edge: speculative capture, or repair from shadow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        main_q <= 1'b0;
    else if (restore_i) main_q <= shadow_q;
    else                main_q <= d_i;
  end

  // shadow sees d_i at the falling edge; the value it takes then is d_i
  assign err_next_o = !restore_i && ((main_q ^ d_i) || meta_i);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (!restore_i) shadow_q <= d_i;
      err_q <= err_next_o;
    end
  end

  assign q_o   = main_q;
  assign err_o = err_q;
endmodule

// File: rtl/tspec_plain_bit.sv
module tspec_plain_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic restore_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= 1'b0;
    else if (!restore_i) q_o <= d_i;
  end
endmodule

// File: rtl/tspec_restore_ctl.sv
module tspec_restore_ctl #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] err_next_i,
  output logic         restore_o
);
  import tspec_pkg::*;

  stage_mode_e mode_q;

  // armed only in RUN; err_next is forced low while recovering
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= MODE_RUN;
    else if (|err_next_i) mode_q <= MODE_RECOVER;
    else                  mode_q <= MODE_RUN;
  end

  assign restore_o = (mode_q == MODE_RECOVER);
endmodule

// File: rtl/tspec_stage_reg.sv
module tspec_stage_reg #(
  parameter int unsigned    W         = tspec_pkg::DEF_WIDTH,
  parameter logic [W-1:0]   PROT_MASK = W'(tspec_pkg::DEF_MASK)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] meta_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] err_bits_o,
  output logic         restore_o
);
  logic [W-1:0] err_next;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (PROT_MASK[i]) begin : g_prot
      tspec_prot_bit u_bit (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .d_i        (d_i[i]),
        .meta_i     (meta_i[i]),
        .restore_i  (restore_o),
        .q_o        (q_o[i]),
        .err_o      (err_bits_o[i]),
        .err_next_o (err_next[i])
      );
    end else begin : g_plain
      tspec_plain_bit u_bit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .d_i       (d_i[i]),
        .restore_i (restore_o),
        .q_o       (q_o[i])
      );
      assign err_bits_o[i] = 1'b0;
      assign err_next[i]   = 1'b0;
    end
  end

  tspec_restore_ctl #(.W(W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_next_i (err_next),
    .restore_o  (restore_o)
  );
endmodule

// File: rtl/tspec_stage_reg_chk.sv
module tspec_stage_reg_chk #(
  parameter int unsigned  W         = 16,
  parameter logic [W-1:0] PROT_MASK = '1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] q_o,
  input logic [W-1:0] err_bits_o,
  input logic         restore_o
);
  p_unguarded_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_bits_o & ~PROT_MASK) == '0);

  p_restore_is_or_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o == (|err_bits_o));

  p_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o);

  p_plain_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> $stable(q_o & ~PROT_MASK));
endmodule

bind tspec_stage_reg tspec_stage_reg_chk #(.W(W), .PROT_MASK(PROT_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .q_o        (q_o),
  .err_bits_o (err_bits_o),
  .restore_o  (restore_o)
);

// File: tb/tspec_stage_reg_test.sv
`timescale 1ns/1ps
module tspec_stage_reg_test;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] M = 16'h3C3C;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] d_i = '0;
  logic [W-1:0] meta_i = '0;
  logic [W-1:0] q_o, err_bits_o;
  logic         restore_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tspec_stage_reg #(.W(W), .PROT_MASK(M)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .d_i(d_i), .meta_i(meta_i),
    .q_o(q_o), .err_bits_o(err_bits_o), .restore_o(restore_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 q", q_o, '0);
    chk("R1 err", err_bits_o, '0);
    chk("R1 restore", W'(restore_o), '0);
    @(negedge clk); #1 rst_ni = 1'b1;
  endtask

  // starts and ends in the low phase
  task automatic t_clean(input logic [W-1:0] v);
    d_i = v;
    @(posedge clk); #1;
    chk("R2 q", q_o, v);
    chk("R2 restore", W'(restore_o), '0);
    @(negedge clk); #1;
    chk("R2 err", err_bits_o, '0);
  endtask

  task automatic t_late(input logic [W-1:0] early, input logic [W-1:0] late_v,
                        input logic [W-1:0] nxt);
    logic [W-1:0] exp_q;
    exp_q = (late_v & M) | (early & ~M);
    d_i = early;
    @(posedge clk); #2 d_i = late_v;
    @(negedge clk); #1;
    chk("R3/R11 err bits", err_bits_o, M & (early ^ late_v));
    chk("R4 restore rise", W'(restore_o), 1);
    d_i = nxt;
    @(posedge clk); #1;
    chk("R5/R6 repaired q", q_o, exp_q);
    chk("R4 restore held", W'(restore_o), 1);
    @(negedge clk); #1;
    chk("R4 restore fall", W'(restore_o), 0);
    chk("R7 no error in recovery", err_bits_o, '0);
  endtask

  task automatic t_meta(input logic [W-1:0] v, input logic [W-1:0] m);
    d_i = v;
    @(posedge clk); #2 meta_i = m;
    @(negedge clk); #1;
    meta_i = '0;
    chk("R8/R9 meta err", err_bits_o, m & M);
    chk("R8/R9 meta restore", W'(restore_o), W'(|(m & M)));
    if (|(m & M)) begin
      @(posedge clk); #1;
      chk("R8 q unchanged", q_o, v);
      @(negedge clk); #1;
      chk("R8 restore done", W'(restore_o), 0);
    end
  endtask

  task automatic t_unguarded_late(input logic [W-1:0] early);
    d_i = early;
    @(posedge clk); #2 d_i = early ^ ~M;
    @(negedge clk); #1;
    chk("R9 no err", err_bits_o, '0);
    chk("R9 no restore", W'(restore_o), 0);
    chk("R9 q keeps edge value", q_o, early);
  endtask

  initial begin
    t_reset();
    t_clean(16'h0000);
    t_clean(16'hBEEF);
    t_clean(16'h1234);
    t_late(16'h0000, 16'hFFFF, 16'h1234);
    t_late(16'hA5A5, 16'hA5A5 ^ 16'h0400, 16'h0000);   // R10 back-to-back
    t_late(16'h5A5A, 16'h5A5A ^ 16'h3C3C, 16'hFFFF);   // R10 again, all guarded bits
    t_clean(16'h0F0F);
    t_meta(16'h6666, 16'h0004);
    t_meta(16'h6666, 16'h0001);
    t_unguarded_late(16'h1111);
    t_clean(16'hC3C3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule